// File: doc/BRIEF.md
# Execute-Chain and Branch Address Sequencer

This block decides which instruction a word-addressed processor fetches next. At each instruction boundary it takes in the decoded class of the instruction that is finishing, together with that instruction's 4-bit R field, the current 4-bit condition code, its effective address and the interrupt and trap requests. From these it produces the next fetch address. It also produces the address to be saved if an interrupt or trap is taken, and a flag that marks the fetched word as the subject of an indirect-execute chain.

An execute instruction sends the fetch to its effective address without moving the instruction address. Chains of execute instructions may be of any length. The block remembers the address of the first execute in the chain. When the chain ends, sequencing resumes just after that head address, unless the final subject branches or loads a new program status. An interrupt or trap during a chain saves the head address, so the whole chain runs again after service. In extended mode a branch may land above the first 2^17 words. One instruction runs there, and then sequencing falls back into the low block.

Top module: `exec_branch_seq`

## Requirements
- R1: After reset, fetch_addr is RESET_ADDR (0), in_subject is 0 and save_valid is 0.
- R2: The op_class encoding is 0 = other, 1 = execute, 2 = branch-on-set, 3 = branch-on-reset, 4 = PSD load/exchange, and 5 to 7 act as other. A step with class 1 moves fetch_addr to the target and sets in_subject. The chain head is captured only when the chain starts, so later execute steps in the same chain keep the first execute's address.
- R3: When a subject that does not branch and does not load a PSD completes, fetch_addr becomes (head + 1) mod 2^17 and in_subject clears.
- R4: Branch-on-set (class 2) is taken exactly when r_field AND cc is nonzero. With r_field = 0 it never branches.
- R5: Branch-on-reset (class 3) is taken exactly when r_field AND cc is zero. With r_field = 0 it always branches.
- R6: A target is the low 17 bits of eff_addr, zero-extended, when ext_mode is 0. It is the full 20-bit eff_addr when ext_mode is 1.
- R7: After one instruction at an address of 2^17 or more, the fall-through address is (address + 1) mod 2^17, unless that instruction is a taken branch.
- R8: A completed non-branching instruction outside a chain advances the address by one, modulo 2^17 (0x1FFFF goes to 0).
- R9: A PSD-class step loads fetch_addr with psd_addr zero-extended and ends any chain.
- R10: A step with irq or trap aborts the current instruction. save_addr is set to the chain head while in a chain and to fetch_addr otherwise. save_valid pulses for one cycle, fetch_addr goes to IRQ_VEC (0x50) or TRAP_VEC (0x40), and the chain ends.
- R11: When trap and irq are both high on a step, the trap wins: save_trap = 1 and fetch_addr = TRAP_VEC.
- R12: With step low, fetch_addr and in_subject hold, save_valid is 0, and the irq, trap and opcode inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction boundary: the fetched instruction finishes this cycle |
| op_class | input | 3 | Decoded class of the finishing instruction |
| r_field | input | 4 | R field of the finishing instruction |
| cc | input | 4 | Current condition code |
| eff_addr | input | 20 | Effective address of the finishing instruction |
| ext_mode | input | 1 | Extended (20-bit) addressing enabled |
| psd_addr | input | 17 | Instruction address delivered by a PSD load |
| irq | input | 1 | Interrupt request |
| trap | input | 1 | Trap request |
| fetch_addr | output | 20 | Address of the next instruction to fetch |
| in_subject | output | 1 | Fetched word is the subject of an execute chain |
| save_valid | output | 1 | One-cycle pulse: an interrupt or trap was taken |
| save_trap | output | 1 | The taken event was a trap |
| save_addr | output | 20 | Return address to be stored for the event |

## Verification
The bench targets several corner cases, and each has a distinct failure signature:

- **Long chains.** A sequencer that advanced the address inside a chain, or that re-captured the head on every execute, would resume several words past the first execute.
- **Trap or interrupt mid-chain.** A wrong design would save the subject's address instead of the head.
- **R field of zero.** A BCS that branched, or a BCR that fell through, would be caught here.
- **Targets above 2^17.** A design that kept the high bits would keep running up in the high block.
- **Wrap and priority.** The wrap at 0x1FFFF and a trap arriving together with an interrupt expose a missing modulo or inverted priority.

// File: rtl/exec_branch_seq.sv
module exec_branch_seq #(
  parameter int AW         = 20,
  parameter int IAW        = 17,
  parameter int RESET_ADDR = 0,
  parameter int TRAP_VEC   = 'h40,
  parameter int IRQ_VEC    = 'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [2:0]    op_class,
  input  logic [3:0]    r_field,
  input  logic [3:0]    cc,
  input  logic [AW-1:0] eff_addr,
  input  logic          ext_mode,
  input  logic [IAW-1:0] psd_addr,
  input  logic          irq,
  input  logic          trap,
  output logic [AW-1:0] fetch_addr,
  output logic          in_subject,
  output logic          save_valid,
  output logic          save_trap,
  output logic [AW-1:0] save_addr
);
  localparam logic [2:0]     OP_EXEC = 3'd1;
  localparam logic [2:0]     OP_BCS  = 3'd2;
  localparam logic [2:0]     OP_BCR  = 3'd3;
  localparam logic [2:0]     OP_PSD  = 3'd4;
  localparam logic [IAW-1:0] ONE     = IAW'(1);
  localparam logic [AW-1:0]  RST_A   = AW'(RESET_ADDR);
  localparam logic [AW-1:0]  TRAP_A  = AW'(TRAP_VEC);
  localparam logic [AW-1:0]  IRQ_A   = AW'(IRQ_VEC);
  localparam int             HW      = AW - IAW;

  logic [AW-1:0]  head_q;
  logic [AW-1:0]  origin;
  logic [IAW-1:0] seq_low;
  logic [AW-1:0]  seq_addr;
  logic [AW-1:0]  target;
  logic           cc_hit;
  logic           taken;

  assign origin   = in_subject ? head_q : fetch_addr;
  assign seq_low  = origin[IAW-1:0] + ONE;
  assign seq_addr = {{HW{1'b0}}, seq_low};
  assign target   = ext_mode ? eff_addr : {{HW{1'b0}}, eff_addr[IAW-1:0]};
  assign cc_hit   = |(r_field & cc);
  assign taken    = (op_class == OP_BCS && cc_hit) || (op_class == OP_BCR && !cc_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_addr <= RST_A;
      in_subject <= 1'b0;
      head_q     <= '0;
      save_valid <= 1'b0;
      save_trap  <= 1'b0;
      save_addr  <= '0;
    end else begin
      save_valid <= 1'b0;
      if (step) begin
        if (trap || irq) begin
          save_valid <= 1'b1;
          save_trap  <= trap;
          save_addr  <= origin;
          fetch_addr <= trap ? TRAP_A : IRQ_A;
          in_subject <= 1'b0;
        end else if (op_class == OP_EXEC) begin
          if (!in_subject) head_q <= fetch_addr;
          fetch_addr <= target;
          in_subject <= 1'b1;
        end else begin
          in_subject <= 1'b0;
          if (op_class == OP_PSD)
            fetch_addr <= {{HW{1'b0}}, psd_addr};
          else if (taken)
            fetch_addr <= target;
          else
            fetch_addr <= seq_addr;
        end
      end
    end
  end
endmodule

// File: rtl/exec_branch_seq_chk.sv
module exec_branch_seq_chk #(
  parameter int AW       = 20,
  parameter int IAW      = 17,
  parameter int TRAP_VEC = 'h40,
  parameter int IRQ_VEC  = 'h50
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic [2:0]    op_class,
  input logic [3:0]    r_field,
  input logic [AW-1:0] eff_addr,
  input logic          irq,
  input logic          trap,
  input logic [AW-1:0] fetch_addr,
  input logic          in_subject,
  input logic          save_valid,
  input logic          save_trap,
  input logic [AW-1:0] save_addr,
  input logic [AW-1:0] head_q
);
  logic plain;
  assign plain = step && !irq && !trap;

  a_r2_exec_enters: assert property (@(posedge clk) disable iff (!rst_n)
    plain && op_class == 3'd1 |=> in_subject && fetch_addr[IAW-1:0] == $past(eff_addr[IAW-1:0]));

  a_r2_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
    plain && op_class == 3'd1 && in_subject |=> head_q == $past(head_q));

  a_r4_bcs_zero_r: assert property (@(posedge clk) disable iff (!rst_n)
    plain && op_class == 3'd2 && r_field == 4'd0 && !in_subject
    |=> fetch_addr == AW'($past(fetch_addr[IAW-1:0]) + IAW'(1)));

  a_r5_bcr_zero_r: assert property (@(posedge clk) disable iff (!rst_n)
    plain && op_class == 3'd3 && r_field == 4'd0
    |=> fetch_addr[IAW-1:0] == $past(eff_addr[IAW-1:0]) && !in_subject);

  a_r10_save_head: assert property (@(posedge clk) disable iff (!rst_n)
    step && (irq || trap) && in_subject |=> save_valid && save_addr == $past(head_q) && !in_subject);

  a_r11_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
    step && trap |=> save_trap && fetch_addr == AW'(TRAP_VEC));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(fetch_addr) && $stable(in_subject) && !save_valid);

  a_r10_irq_vec: assert property (@(posedge clk) disable iff (!rst_n)
    step && irq && !trap |=> !save_trap && fetch_addr == AW'(IRQ_VEC));
endmodule

bind exec_branch_seq exec_branch_seq_chk #(
  .AW(AW), .IAW(IAW), .TRAP_VEC(TRAP_VEC), .IRQ_VEC(IRQ_VEC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .op_class(op_class), .r_field(r_field),
  .eff_addr(eff_addr), .irq(irq), .trap(trap), .fetch_addr(fetch_addr),
  .in_subject(in_subject), .save_valid(save_valid), .save_trap(save_trap),
  .save_addr(save_addr), .head_q(head_q)
);

// File: tb/test_exec_branch_seq.sv
`timescale 1ns/100ps
module test_exec_branch_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        step = 0;
  logic [2:0]  op_class = 0;
  logic [3:0]  r_field = 0;
  logic [3:0]  cc = 0;
  logic [19:0] eff_addr = 0;
  logic        ext_mode = 0;
  logic [16:0] psd_addr = 0;
  logic        irq = 0;
  logic        trap = 0;
  logic [19:0] fetch_addr;
  logic        in_subject;
  logic        save_valid;
  logic        save_trap;
  logic [19:0] save_addr;

  exec_branch_seq i_exec_branch_seq (.*);

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [19:0] m_fetch, m_head, m_sa;
  logic        m_chain, m_sv, m_st;

  function automatic logic [19:0] low17(input logic [19:0] a);
    return {3'b0, a[16:0]};
  endfunction

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [19:0] org, tgt;
    logic hit, tk;
    m_sv = 0;
    if (!step) return;
    org = m_chain ? m_head : m_fetch;
    tgt = ext_mode ? eff_addr : low17(eff_addr);
    hit = (r_field & cc) != 0;
    tk  = (op_class == 2 && hit) || (op_class == 3 && !hit);
    if (trap || irq) begin
      m_sv = 1; m_st = trap; m_sa = org;
      m_fetch = trap ? 20'h40 : 20'h50; m_chain = 0;
    end else if (op_class == 1) begin
      if (!m_chain) m_head = m_fetch;
      m_fetch = tgt; m_chain = 1;
    end else begin
      m_chain = 0;
      if (op_class == 4) m_fetch = {3'b0, psd_addr};
      else if (tk) m_fetch = tgt;
      else m_fetch = low17(org + 20'd1);
    end
  endtask

  task automatic cyc(input string req, input bit s, input logic [2:0] op, input logic [3:0] r,
                     input logic [3:0] c, input logic [19:0] ea, input bit ex,
                     input logic [16:0] pa, input bit iq, input bit tp);
    step = s; op_class = op; r_field = r; cc = c; eff_addr = ea;
    ext_mode = ex; psd_addr = pa; irq = iq; trap = tp;
    model_step();
    @(posedge clk); #1;
    chk({req, " fetch_addr"}, fetch_addr, m_fetch);
    chk({req, " in_subject"}, {19'b0, in_subject}, {19'b0, m_chain});
    chk({req, " save_valid"}, {19'b0, save_valid}, {19'b0, m_sv});
    if (m_sv) begin
      chk({req, " save_trap"}, {19'b0, save_trap}, {19'b0, m_st});
      chk({req, " save_addr"}, save_addr, m_sa);
    end
  endtask

  function automatic string tag_of(input bit s, input logic [2:0] op, input bit iq, input bit tp);
    if (!s) return "R12";
    if (tp) return "R11";
    if (iq) return "R10";
    case (op)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R9";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    m_fetch = 0; m_head = 0; m_sa = 0; m_chain = 0; m_sv = 0; m_st = 0;
    chk("R1 reset fetch", fetch_addr, 20'h0);
    chk("R1 reset subject", {19'b0, in_subject}, 20'h0);
    chk("R1 reset save_valid", {19'b0, save_valid}, 20'h0);

    // R8 wrap at top of low block
    cyc("R9", 1, 4, 0, 0, 0, 0, 17'h1FFFF, 0, 0);
    cyc("R8 wrap", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 wrap to zero", fetch_addr, 20'h0);

    // R2/R3 long chain: head at 0x100
    cyc("R9", 1, 4, 0, 0, 0, 0, 17'h100, 0, 0);
    for (int k = 0; k < 6; k++) cyc("R2 chain", 1, 1, 0, 0, 20'h2000 + k, 0, 0, 0, 0);
    cyc("R3 end", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 resume after head", fetch_addr, 20'h101);

    // R10 trap and interrupt mid-chain
    cyc("R9", 1, 4, 0, 0, 0, 0, 17'h200, 0, 0);
    cyc("R2", 1, 1, 0, 0, 20'h3000, 0, 0, 0, 0);
    cyc("R2", 1, 1, 0, 0, 20'h3100, 0, 0, 0, 0);
    cyc("R10 trap", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 save head", save_addr, 20'h200);
    cyc("R9", 1, 4, 0, 0, 0, 0, 17'h300, 0, 0);
    cyc("R2", 1, 1, 0, 0, 20'h3000, 0, 0, 0, 0);
    cyc("R10 irq", 1, 2, 4'hF, 4'hF, 20'h7, 0, 0, 1, 0);
    chk("R10 irq vector", fetch_addr, 20'h50);

    // R11 both at once
    cyc("R11", 1, 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R11 trap vector", fetch_addr, 20'h40);

    // R4/R5 zero R field
    cyc("R4 r0", 1, 2, 0, 4'hF, 20'h999, 0, 0, 0, 0);
    chk("R4 no branch", fetch_addr, 20'h41);
    cyc("R5 r0", 1, 3, 0, 4'hF, 20'h999, 0, 0, 0, 0);
    chk("R5 always branch", fetch_addr, 20'h999);
    cyc("R4 hit", 1, 2, 4'h2, 4'h3, 20'h123, 0, 0, 0, 0);
    cyc("R5 hit", 1, 3, 4'h2, 4'h3, 20'h456, 0, 0, 0, 0);
    chk("R5 not taken", fetch_addr, 20'h124);

    // R6/R7 high target
    cyc("R6 ext", 1, 3, 0, 0, 20'hA1FFF, 1, 0, 0, 0);
    chk("R6 full target", fetch_addr, 20'hA1FFF);
    cyc("R7 fallback", 1, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 low block", fetch_addr, 20'h02000);
    cyc("R6 no ext", 1, 3, 0, 0, 20'hA1234, 0, 0, 0, 0);
    chk("R6 masked", fetch_addr, 20'h01234);

    // R12 idle ignores inputs
    cyc("R12 idle", 0, 1, 4'hF, 4'hF, 20'hFFFFF, 1, 17'h5, 1, 1);
    chk("R12 held", fetch_addr, 20'h01234);

    for (int n = 0; n < 4000; n++) begin
      logic s, iq, tp; logic [2:0] op;
      s  = ($urandom % 4) != 0;
      op = 3'($urandom % 6);
      iq = ($urandom % 12) == 0;
      tp = ($urandom % 16) == 0;
      cyc(tag_of(s, op, iq, tp), s, op, 4'($urandom), 4'($urandom), 20'($urandom),
          1'($urandom), 17'($urandom), iq, tp);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule